// File: doc/BRIEF.md
# SCL Clock Waveform Generator

This block produces the serial clock of a two-wire bus controller from programmable high and low period counts, both in core clock cycles. Two count pairs are provided, one for the standard speed and one for the fast speed, and a select input chooses between them. The clock output is open-drain style: `scl_pull` asks the pad to drive the line low, and releasing it lets the line float high. The generator watches the real line level through a synchroniser, so a target that holds the clock low stretches the high phase.

Four one-cycle strobes are given to the byte sequencer next to it. Two mark the cycle just before each clock edge, so the sequencer can change the data line while the clock is still low. The other two mark the middle of each phase. The sequencer builds start and stop conditions and the data hold delay on its own; this block does not do that.

The controller has four states. `PH_IDLE` leaves the line released and keeps the counter at zero. `PH_LOW` pulls the line low and counts down the low count. `PH_WAIT_HI` has released the line and waits for the synchronised line to read high. `PH_HIGH` counts down the high count. The transitions are as follows. IDLE goes to LOW when `run_en` is high, and the selected counts are captured then. LOW goes to WAIT_HI when its count reaches zero. WAIT_HI goes to HIGH once the synchronised line is high. HIGH goes to LOW when its count reaches zero. From any state the controller goes back to IDLE when `run_en` is low.

Top module: `scl_waveform_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `scl_pull` is 0 and all four strobes are 0 as long as `run_en` stays 0.
- R2: The low phase holds `scl_pull` at 1 for exactly L+1 consecutive cycles. L is the effective low count of the selected pair. The count starts in the first cycle the line is pulled, not when the line reads low.
- R3: With no outside stretching, the high phase (consecutive cycles of `scl_pull` = 0 between two low phases) lasts exactly H+8 cycles, where H is the effective high count.
- R4: If an outside device holds `scl_sense` low for S cycles starting at the release, the high phase lasts exactly H+8+S cycles. The high count only starts after the line is seen high through the two-stage synchroniser.
- R5: `fast_sel` = 0 uses `std_hi_cnt`/`std_lo_cnt` and `fast_sel` = 1 uses `fast_hi_cnt`/`fast_lo_cnt`.
- R6: A low count below MIN_LO_CNT (default 6) acts as MIN_LO_CNT. A high count below MIN_HI_CNT (default 4) acts as MIN_HI_CNT.
- R7: Counts and `fast_sel` are captured only when leaving IDLE. Changes made while running have no effect on the waveform until the block is disabled and enabled again.
- R8: `pre_fall` is 1 exactly in the cycle before each cycle where `scl_pull` goes from 0 to 1. `pre_rise` is 1 exactly in the last cycle of each low phase.
- R9: `mid_low` pulses once per low phase, at 0-based cycle ceil(L/2) of that phase. `mid_high` pulses once per high phase, at 0-based cycle S+3+ceil((H+4)/2) counted from the release. No two strobes are ever high together.
- R10: When `run_en` is seen low at a clock edge, `scl_pull` is 0 from the next cycle onward and the strobes stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enables clock generation; low releases the line |
| fast_sel | input | 1 | 0 selects the standard pair, 1 the fast pair |
| std_hi_cnt | input | 16 | Standard speed high count |
| std_lo_cnt | input | 16 | Standard speed low count |
| fast_hi_cnt | input | 16 | Fast speed high count |
| fast_lo_cnt | input | 16 | Fast speed low count |
| scl_sense | input | 1 | Actual clock line level (asynchronous) |
| scl_pull | output | 1 | 1 drives the clock line low |
| pre_rise | output | 1 | Strobe in the cycle before the line is released |
| pre_fall | output | 1 | Strobe in the cycle before the line is pulled low |
| mid_high | output | 1 | Strobe at the middle of the high phase |
| mid_low | output | 1 | Strobe at the middle of the low phase |

## Verification
The bench measures every phase length cycle by cycle with stretches of zero, one and several cycles. A design that counted the high phase from the release instead of from the sensed level would give high phases that do not grow with the stretch. A design that waited for the line to read low before counting would give low phases that are too long. Counts below the minimum and counts exactly at it are run, so a missing or off-by-one clamp shows up as a wrong period. Counts are changed while the block is running, which catches a design that samples the inputs live. The bench also turns `run_en` off in the middle of a phase to check that the line is released in the next cycle.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LOW     = 2'd1,
        PH_WAIT_HI = 2'd2,
        PH_HIGH    = 2'd3
    } scl_phase_e;

    // Total fixed overhead of the high phase beyond the programmed count
    localparam int HIGH_OVERHEAD = 8;
endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/scl_count_sel.sv
module scl_count_sel #(
    parameter int CNT_W      = 16,
    parameter int MIN_HI_CNT = 4,
    parameter int MIN_LO_CNT = 6
) (
    input  logic             fast_sel,
    input  logic [CNT_W-1:0] std_hi,
    input  logic [CNT_W-1:0] std_lo,
    input  logic [CNT_W-1:0] fast_hi,
    input  logic [CNT_W-1:0] fast_lo,
    output logic [CNT_W-1:0] hi_eff,
    output logic [CNT_W-1:0] lo_eff
);
    localparam logic [CNT_W-1:0] HI_FLOOR = CNT_W'(MIN_HI_CNT);
    localparam logic [CNT_W-1:0] LO_FLOOR = CNT_W'(MIN_LO_CNT);

    logic [CNT_W-1:0] hi_raw, lo_raw;

    always_comb begin
        hi_raw = fast_sel ? fast_hi : std_hi;
        lo_raw = fast_sel ? fast_lo : std_lo;
        hi_eff = (hi_raw < HI_FLOOR) ? HI_FLOOR : hi_raw;
        lo_eff = (lo_raw < LO_FLOOR) ? LO_FLOOR : lo_raw;
    end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import sclgen_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CNT_W-1:0] hi_eff,
    input  logic [CNT_W-1:0] lo_eff,
    input  logic             bus_high,
    output logic             scl_pull,
    output logic             pre_rise,
    output logic             pre_fall,
    output logic             mid_high,
    output logic             mid_low
);
    localparam int CW          = CNT_W + 1;
    // WAIT_HI lasts SYNC_STAGES+1 cycles and HIGH lasts load+1 cycles
    localparam int HI_LOAD_ADD = HIGH_OVERHEAD - SYNC_STAGES - 2;

    scl_phase_e        st_q, st_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [CNT_W-1:0]  caph_q, caph_d, capl_q, capl_d;
    logic [CW-1:0]     hi_load, lo_load, hi_half, lo_half;
    logic              cnt_zero;

    always_comb begin
        hi_load  = {1'b0, caph_q} + CW'(HI_LOAD_ADD);
        lo_load  = {1'b0, capl_q};
        hi_half  = hi_load >> 1;
        lo_half  = lo_load >> 1;
        cnt_zero = (cnt_q == '0);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PH_IDLE;
            cnt_q  <= '0;
            caph_q <= '0;
            capl_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            caph_q <= caph_d;
            capl_q <= capl_d;
        end
    end

    // Next state and counter
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        caph_d = caph_q;
        capl_d = capl_q;
        if (!run_en) begin
            st_d  = PH_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                PH_IDLE: begin
                    st_d   = PH_LOW;
                    cnt_d  = {1'b0, lo_eff};
                    caph_d = hi_eff;
                    capl_d = lo_eff;
                end
                PH_LOW: begin
                    if (cnt_zero) st_d  = PH_WAIT_HI;
                    else          cnt_d = cnt_q - 1'b1;
                end
                PH_WAIT_HI: begin
                    if (bus_high) begin
                        st_d  = PH_HIGH;
                        cnt_d = hi_load;
                    end
                end
                PH_HIGH: begin
                    if (cnt_zero) begin
                        st_d  = PH_LOW;
                        cnt_d = lo_load;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    st_d  = PH_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        scl_pull = (st_q == PH_LOW);
        pre_rise = run_en && (st_q == PH_LOW) && cnt_zero;
        pre_fall = run_en && (((st_q == PH_HIGH) && cnt_zero) || (st_q == PH_IDLE));
        mid_low  = (st_q == PH_LOW)  && (cnt_q == lo_half);
        mid_high = (st_q == PH_HIGH) && (cnt_q == hi_half);
    end
endmodule

// File: rtl/scl_waveform_gen.sv
module scl_waveform_gen #(
    parameter int CNT_W       = 16,
    parameter int MIN_HI_CNT  = 4,
    parameter int MIN_LO_CNT  = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             fast_sel,
    input  logic [CNT_W-1:0] std_hi_cnt,
    input  logic [CNT_W-1:0] std_lo_cnt,
    input  logic [CNT_W-1:0] fast_hi_cnt,
    input  logic [CNT_W-1:0] fast_lo_cnt,
    input  logic             scl_sense,
    output logic             scl_pull,
    output logic             pre_rise,
    output logic             pre_fall,
    output logic             mid_high,
    output logic             mid_low
);
    logic [CNT_W-1:0] hi_eff, lo_eff;
    logic             bus_high;

    scl_count_sel #(
        .CNT_W(CNT_W), .MIN_HI_CNT(MIN_HI_CNT), .MIN_LO_CNT(MIN_LO_CNT)
    ) u_sel (
        .fast_sel(fast_sel),
        .std_hi  (std_hi_cnt),
        .std_lo  (std_lo_cnt),
        .fast_hi (fast_hi_cnt),
        .fast_lo (fast_lo_cnt),
        .hi_eff  (hi_eff),
        .lo_eff  (lo_eff)
    );

    scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(scl_sense),
        .d_sync (bus_high)
    );

    scl_phase_fsm #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .hi_eff  (hi_eff),
        .lo_eff  (lo_eff),
        .bus_high(bus_high),
        .scl_pull(scl_pull),
        .pre_rise(pre_rise),
        .pre_fall(pre_fall),
        .mid_high(mid_high),
        .mid_low (mid_low)
    );
endmodule

// File: rtl/scl_waveform_chk.sv
module scl_waveform_chk (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic scl_pull,
    input logic pre_rise,
    input logic pre_fall,
    input logic mid_high,
    input logic mid_low
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_release: assert (!scl_pull)
                else $error("R1 line pulled during reset");
        end
    end

    a_r10_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !scl_pull);

    a_r8_pre_fall_next: assert property (@(posedge clk) disable iff (!rst_n)
        pre_fall |=> scl_pull);

    a_r8_pre_rise_next: assert property (@(posedge clk) disable iff (!rst_n)
        pre_rise |=> !scl_pull);

    a_r8_fall_announced: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> $past(pre_fall));

    a_r2_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull && !pre_rise && run_en) |=> scl_pull);

    a_r9_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_rise, pre_fall, mid_high, mid_low}));
endmodule

bind scl_waveform_gen scl_waveform_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .scl_pull(scl_pull),
    .pre_rise(pre_rise),
    .pre_fall(pre_fall),
    .mid_high(mid_high),
    .mid_low (mid_low)
);

// File: tb/scl_waveform_gen_test.sv
module scl_waveform_gen_test;
    localparam int MINH = 4;
    localparam int MINL = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        fast_sel = 1'b0;
    logic [15:0] std_hi_cnt = '0, std_lo_cnt = '0, fast_hi_cnt = '0, fast_lo_cnt = '0;
    logic        ext_hold = 1'b0;
    logic        scl_sense;
    logic        scl_pull, pre_rise, pre_fall, mid_high, mid_low;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic last_pf = 1'b0;
    logic last_pr = 1'b0;

    always #2 clk = ~clk;

    assign scl_sense = ~scl_pull & ~ext_hold;

    scl_waveform_gen uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .fast_sel(fast_sel),
        .std_hi_cnt(std_hi_cnt), .std_lo_cnt(std_lo_cnt),
        .fast_hi_cnt(fast_hi_cnt), .fast_lo_cnt(fast_lo_cnt),
        .scl_sense(scl_sense), .scl_pull(scl_pull), .pre_rise(pre_rise),
        .pre_fall(pre_fall), .mid_high(mid_high), .mid_low(mid_low)
    );

    function automatic int eff(input int v, input int lim);
        return (v < lim) ? lim : v;
    endfunction

    task automatic check(input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic step();
        last_pf = pre_fall;
        last_pr = pre_rise;
        @(negedge clk);
    endtask

    // Measures one low phase followed by one high phase; l and h are effective counts
    task automatic period(input int l, input int h, input int s, input bit chk_pf, input string tag);
        int guard = 0;
        int idx;
        int ml = -1;
        int mh = -1;
        while (!scl_pull && guard < 5000) begin step(); guard++; end
        if (chk_pf) check({tag, " R8 pre_fall before low"}, int'(last_pf), 1);
        idx = 0;
        while (scl_pull && idx < 5000) begin
            if (mid_low) ml = idx;
            idx++;
            step();
        end
        check({tag, " R2 low length"}, idx, l + 1);
        check({tag, " R9 mid_low index"}, ml, (l + 1) / 2);
        check({tag, " R8 pre_rise last low"}, int'(last_pr), 1);
        idx = 0;
        while (!scl_pull && idx < 5000) begin
            ext_hold = (idx < s);
            if (mid_high) mh = idx;
            idx++;
            step();
        end
        ext_hold = 1'b0;
        check({tag, " R3 R4 high length"}, idx, h + 8 + s);
        check({tag, " R9 mid_high index"}, mh, s + 3 + (h + 5) / 2);
    endtask

    task automatic stop_run(input string tag);
        run_en = 1'b0;
        step();
        for (int i = 0; i < 4; i++) begin
            check({tag, " R10 released after disable"},
                  int'({scl_pull, pre_rise, pre_fall, mid_high, mid_low}), 0);
            step();
        end
    endtask

    task automatic set_counts(input int sh, input int sl, input int fh, input int fl, input bit fs);
        std_hi_cnt  = 16'(sh);
        std_lo_cnt  = 16'(sl);
        fast_hi_cnt = 16'(fh);
        fast_lo_cnt = 16'(fl);
        fast_sel    = fs;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        check("R1 reset state", int'({scl_pull, pre_rise, pre_fall, mid_high, mid_low}), 0);
        rst_n = 1'b1;
        step();
        check("R1 idle after reset", int'({scl_pull, pre_rise, pre_fall, mid_high, mid_low}), 0);

        // Standard pair
        set_counts(12, 20, 7, 9, 1'b0);
        run_en = 1'b1;
        period(20, 12, 0, 1'b0, "std R5");
        period(20, 12, 0, 1'b1, "std R5");
        stop_run("std");

        // Fast pair
        set_counts(12, 20, 7, 9, 1'b1);
        run_en = 1'b1;
        period(9, 7, 0, 1'b0, "fast R5");
        period(9, 7, 0, 1'b1, "fast R5");
        stop_run("fast");

        // Clamp below and at the minimum
        set_counts(0, 2, 7, 9, 1'b0);
        run_en = 1'b1;
        period(MINL, MINH, 0, 1'b0, "clamp R6");
        period(MINL, MINH, 0, 1'b1, "clamp R6");
        stop_run("clamp");
        set_counts(MINH, MINL, 7, 9, 1'b0);
        run_en = 1'b1;
        period(MINL, MINH, 0, 1'b0, "at min R6");
        stop_run("at min");

        // Stretching
        set_counts(10, 11, 7, 9, 1'b0);
        run_en = 1'b1;
        period(11, 10, 5, 1'b0, "stretch5 R4");
        period(11, 10, 1, 1'b1, "stretch1 R4");
        period(11, 10, 0, 1'b1, "stretch0 R4");
        // Disable while in the low phase
        repeat (3) step();
        stop_run("mid low");

        // Counts change while running are ignored
        set_counts(6, 10, 7, 9, 1'b0);
        run_en = 1'b1;
        period(10, 6, 0, 1'b0, "live R7");
        set_counts(30, 30, 25, 25, 1'b1);
        period(10, 6, 0, 1'b1, "live R7");
        period(10, 6, 2, 1'b1, "live R7");
        stop_run("live");
        run_en = 1'b1;
        period(25, 25, 0, 1'b0, "restart R7");
        stop_run("restart");

        // Random mix
        for (int it = 0; it < 10; it++) begin
            int sh = $urandom_range(0, 40);
            int sl = $urandom_range(0, 40);
            int fh = $urandom_range(0, 40);
            int fl = $urandom_range(0, 40);
            int fs = $urandom_range(0, 1);
            int st = $urandom_range(0, 6);
            int eh = eff(fs ? fh : sh, MINH);
            int el = eff(fs ? fl : sl, MINL);
            set_counts(sh, sl, fh, fl, fs[0]);
            run_en = 1'b1;
            period(el, eh, 0, 1'b0, "rand R2 R5 R6");
            period(el, eh, st, 1'b1, "rand R4");
            stop_run("rand");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule